// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Masked-Write Aliases

This block is one general-purpose I/O port of eight pins behind a simple register interface: an address, a write enable, a 32-bit write bus and a 32-bit read bus. Three control registers are kept per port. The mode register decides, pin by pin, whether the pin is under GPIO control or handed to its alternate function. The drive-enable register decides whether a GPIO pin drives its pad. The level register holds the value driven. A fourth, read-only register shows the synchronized pad levels.

Each control register can be reached through two addresses. The direct address replaces all eight bits at once. The masked alias sits at the same relative offset above a fixed alias base. In a masked write the upper byte of the write data selects the pins to change and the lower byte gives their new values, so software can flip one pin without first reading the register. The pad inputs pass through a two-flop synchronizer. The synchronized levels go to the input register and also leave the block for the interrupt and debounce logic that sits downstream.

Top module: `gpio_port_mw`

## Requirements
- R1: After reset the mode, drive-enable and level registers are all zero. Every pin is then an alternate-function input, `pad_oe` is 0x00, and every register address reads as zero.
- R2: A write to a direct address replaces the whole register with `wr_data[7:0]`. Write-data bits 31:8 have no effect. The direct addresses are mode 0x00, drive-enable 0x10 and level 0x20.
- R3: A write to a masked alias changes pin i only when its strobe `wr_data[8+i]` is 1. The pin then takes the value `wr_data[i]`. Pins whose strobe is 0 keep their value. The masked aliases are mode 0x80, drive-enable 0x90 and level 0xA0.
- R4: A read returns the addressed register in bits 7:0 and zeros in bits 31:8. This holds for the direct addresses and for the masked aliases, and a masked alias returns the same value as its direct address.
- R5: `pad_out` equals the level register. `pad_oe[i]` is 1 exactly when the mode bit i and the drive-enable bit i are both 1.
- R6: A pin whose mode bit is 0 never has `pad_oe` set, whatever its drive-enable bit holds.
- R7: A change on `pad_in` appears on `pin_sync` after the second rising clock edge. It does not appear after the first. The input register at 0x30 reads `pin_sync` in bits 7:0.
- R8: Writes to the input register (0x30), to the masked offset 0xB0 and to unmapped addresses such as 0x40 change no register. Reads from unmapped addresses return zero.
- R9: A write takes effect at the clock edge on which `wr_en` is sampled high. The read bus is combinational from `addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| pad_in | input | 8 | Raw pad levels |
| pad_out | output | 8 | Level driven onto each pad |
| pad_oe | output | 8 | Pad drive enable (1 = drive) |
| pin_sync | output | 8 | Synchronized pad levels for downstream blocks |

## Verification
The bench builds the port with its defaults: eight pins, an 8-bit address, the alias base at 0x80 and two synchronizer stages. With these values every strobe and value bit of a masked write fits in the low 16 bits of the data word. A single write can therefore set some pins, clear others and leave the rest alone. The same bench can also reach the boundary between the last direct offset (0x30) and the alias region, and it can see the exact cycle in which a pad change crosses the two flops.

// File: rtl/gpmw_pkg.sv
package gpmw_pkg;

    // Register selected by an address, after the alias region is stripped off.
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_DRIVE,
        SEL_LEVEL,
        SEL_INPUT
    } reg_sel_e;

    // Relative offsets inside a port (the decoder depends on them).
    localparam logic [7:0] OFS_MODE  = 8'h00;
    localparam logic [7:0] OFS_DRIVE = 8'h10;
    localparam logic [7:0] OFS_LEVEL = 8'h20;
    localparam logic [7:0] OFS_INPUT = 8'h30;

    localparam int unsigned NUM_CTL = 3;

endpackage

// File: rtl/gpmw_decode.sv
module gpmw_decode
    import gpmw_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned MASK_BASE = 8'h80
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic              masked
);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(MASK_BASE);

    logic [ADDR_W-1:0] rel;

    always_comb begin
        masked = (addr >= BASE);
        rel    = masked ? (addr - BASE) : addr;
        unique case (rel)
            ADDR_W'(OFS_MODE):  sel = SEL_MODE;
            ADDR_W'(OFS_DRIVE): sel = SEL_DRIVE;
            ADDR_W'(OFS_LEVEL): sel = SEL_LEVEL;
            ADDR_W'(OFS_INPUT): sel = masked ? SEL_NONE : SEL_INPUT;
            default:            sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/gpmw_ctlreg.sv
module gpmw_ctlreg #(
    parameter int unsigned NPINS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic               masked,
    input  logic [NPINS-1:0]   wval,
    input  logic [NPINS-1:0]   wstrb,
    output logic [NPINS-1:0]   q
);
    logic [NPINS-1:0] nxt;

    for (genvar i = 0; i < NPINS; i++) begin : g_bit
        // Direct writes take every bit; masked writes only strobed bits.
        assign nxt[i] = (!masked || wstrb[i]) ? wval[i] : q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/gpmw_sync.sv
module gpmw_sync #(
    parameter int unsigned NPINS  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] d,
    output logic [NPINS-1:0] q
);
    logic [NPINS-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_port_mw.sv
module gpio_port_mw
    import gpmw_pkg::*;
#(
    parameter int unsigned NPINS       = 8,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned MASK_BASE   = 8'h80,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pin_sync
);
    localparam int unsigned STRB_LO = NPINS;
    localparam int unsigned STRB_HI = 2 * NPINS - 1;

    reg_sel_e         sel;
    logic             masked;
    logic [NUM_CTL-1:0] ctl_wr;
    logic [NPINS-1:0] ctl_q [NUM_CTL];
    logic [NPINS-1:0] mode_q, drive_q, level_q;

    gpmw_decode #(
        .ADDR_W    (ADDR_W),
        .MASK_BASE (MASK_BASE)
    ) u_dec (
        .addr   (addr),
        .sel    (sel),
        .masked (masked)
    );

    // Write steering: index 0 mode, 1 drive-enable, 2 level.
    always_comb begin
        ctl_wr = '0;
        unique case (sel)
            SEL_MODE:  ctl_wr[0] = wr_en;
            SEL_DRIVE: ctl_wr[1] = wr_en;
            SEL_LEVEL: ctl_wr[2] = wr_en;
            default:   ctl_wr    = '0;
        endcase
    end

    for (genvar r = 0; r < NUM_CTL; r++) begin : g_ctl
        gpmw_ctlreg #(
            .NPINS (NPINS)
        ) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (ctl_wr[r]),
            .masked (masked),
            .wval   (wr_data[NPINS-1:0]),
            .wstrb  (wr_data[STRB_HI:STRB_LO]),
            .q      (ctl_q[r])
        );
    end

    assign mode_q  = ctl_q[0];
    assign drive_q = ctl_q[1];
    assign level_q = ctl_q[2];

    gpmw_sync #(
        .NPINS  (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_sync)
    );

    // Pad drive: only GPIO-mode pins may enable their driver.
    assign pad_out = level_q;
    assign pad_oe  = mode_q & drive_q;

    always_comb begin
        rd_data = '0;
        unique case (sel)
            SEL_MODE:  rd_data[NPINS-1:0] = mode_q;
            SEL_DRIVE: rd_data[NPINS-1:0] = drive_q;
            SEL_LEVEL: rd_data[NPINS-1:0] = level_q;
            SEL_INPUT: rd_data[NPINS-1:0] = pin_sync;
            default:   rd_data = '0;
        endcase
    end

    if (DATA_W > 2 * NPINS) begin : g_hi
        logic unused_wr_hi;
        assign unused_wr_hi = ^wr_data[DATA_W-1:2*NPINS];
    end
endmodule

// File: rtl/gpmw_checker.sv
module gpmw_checker #(
    parameter int unsigned NPINS     = 8,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned MASK_BASE = 8'h80
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic [NPINS-1:0]  pad_in,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pin_sync
);
    localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] A_LEVEL  = ADDR_W'(8'h20);
    localparam logic [ADDR_W-1:0] A_INPUT  = ADDR_W'(8'h30);
    localparam logic [ADDR_W-1:0] A_MBASE  = ADDR_W'(MASK_BASE);
    localparam logic [ADDR_W-1:0] A_MLEVEL = ADDR_W'(MASK_BASE + 8'h20);

    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1: drivers are off in the first cycle after reset release
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0));

    // R3: masked level write keeps unstrobed pins, sets strobed ones
    a_r3_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_MLEVEL) |=>
        ((pad_out & ~$past(wr_data[2*NPINS-1:NPINS])) ==
         ($past(pad_out) & ~$past(wr_data[2*NPINS-1:NPINS]))));

    a_r3_masked_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_MLEVEL) |=>
        ((pad_out & $past(wr_data[2*NPINS-1:NPINS])) ==
         ($past(wr_data[NPINS-1:0]) & $past(wr_data[2*NPINS-1:NPINS]))));

    // R2: direct level write replaces the whole register
    a_r2_direct_level: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_LEVEL) |=> (pad_out == $past(wr_data[NPINS-1:0])));

    // R4: masked alias reads carry zeros above the pin field
    a_r4_alias_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= A_MBASE) |-> (rd_data[DATA_W-1:NPINS] == '0));

    // R6: clearing every mode bit turns every driver off
    a_r6_mode_gates_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_MODE && wr_data[NPINS-1:0] == '0) |=> (pad_oe == '0));

    // R7: synchronized input lags the pad by two edges
    a_r7_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (pin_sync == $past(pad_in, 2)));

    // R8: input register writes leave the pads alone
    a_r8_input_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_INPUT) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_port_mw gpmw_checker #(
    .NPINS     (NPINS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MASK_BASE (MASK_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pin_sync (pin_sync)
);

// File: tb/tb_gpio_port_mw.sv
`timescale 1ns/1ps
module tb_gpio_port_mw;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out, pad_oe, pin_sync;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the three control registers
    logic [7:0] m_mode = '0, m_drive = '0, m_level = '0;

    always #2.5 clk = ~clk;

    gpio_port_mw dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pin_sync(pin_sync)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    function automatic logic [7:0] mmerge(logic [7:0] old, logic [31:0] d);
        return (old & ~d[15:8]) | (d[7:0] & d[15:8]);
    endfunction

    task automatic check_pads(input string tag);
        chk({tag, " pad_out"}, {24'h0, pad_out}, {24'h0, m_level});
        chk({tag, " pad_oe"},  {24'h0, pad_oe},  {24'h0, m_mode & m_drive});
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(8'h00, d); chk("R1 mode", d, 0);
        rd(8'h10, d); chk("R1 drive", d, 0);
        rd(8'h20, d); chk("R1 level", d, 0);
        chk("R1 pad_oe", {24'h0, pad_oe}, 0);
    endtask

    task automatic t_direct;
        logic [31:0] d;
        wr(8'h00, 32'hFFFF_FF5A); m_mode = 8'h5A;
        wr(8'h10, 32'h1234_56F0); m_drive = 8'hF0;
        wr(8'h20, 32'hABCD_EF3C); m_level = 8'h3C;
        rd(8'h00, d); chk("R2 mode", d, 32'h5A);
        rd(8'h10, d); chk("R2 drive", d, 32'hF0);
        rd(8'h20, d); chk("R2 level", d, 32'h3C);
        check_pads("R5 direct");
    endtask

    task automatic t_timing;
        // R9: value visible right after the sampling edge, not before
        @(negedge clk);
        addr = 8'h20; wr_data = 32'h0000_00C3; wr_en = 1'b1;
        #1 chk("R9 before edge", {24'h0, pad_out}, {24'h0, m_level});
        @(posedge clk); #1;
        wr_en = 1'b0; m_level = 8'hC3;
        chk("R9 after edge", {24'h0, pad_out}, 32'hC3);
        chk("R9 read comb", rd_data, 32'hC3);
    endtask

    task automatic t_masked;
        logic [31:0] d;
        d = 32'h0000_0F05;
        wr(8'hA0, d); m_level = mmerge(m_level, d);
        check_pads("R3 level mask");
        d = 32'hFFFF_8000; // upper junk, strobe pin 7 to 0
        wr(8'hA0, d); m_level = mmerge(m_level, d);
        check_pads("R3 level pin7");
        d = 32'h0000_0000; // no strobe: nothing changes
        wr(8'h90, 32'h0000_00FF); m_drive = mmerge(m_drive, 32'h0000_00FF);
        rd(8'h10, d); chk("R3 zero strobe", d, {24'h0, m_drive});
        wr(8'h90, 32'h0000_FF0F); m_drive = 8'h0F;
        wr(8'h80, 32'h0000_0381); m_mode = mmerge(m_mode, 32'h0000_0381);
        rd(8'h00, d); chk("R3 mode mask", d, {24'h0, m_mode});
        check_pads("R5 masked");
    endtask

    task automatic t_alias_read;
        logic [31:0] d;
        rd(8'h80, d); chk("R4 alias mode", d, {24'h0, m_mode});
        rd(8'h90, d); chk("R4 alias drive", d, {24'h0, m_drive});
        rd(8'hA0, d); chk("R4 alias level", d, {24'h0, m_level});
    endtask

    task automatic t_gating;
        wr(8'h10, 32'hFF); m_drive = 8'hFF;
        wr(8'h00, 32'h00); m_mode = 8'h00;
        chk("R6 all alt", {24'h0, pad_oe}, 0);
        wr(8'h80, 32'h0000_1010); m_mode = 8'h10;
        chk("R6 one gpio", {24'h0, pad_oe}, 32'h10);
    endtask

    task automatic t_sync;
        logic [31:0] d;
        @(negedge clk); pad_in = 8'hA5;
        @(posedge clk); #1;
        chk("R7 one edge", {24'h0, pin_sync}, 0);
        @(posedge clk); #1;
        chk("R7 two edges", {24'h0, pin_sync}, 32'hA5);
        rd(8'h30, d); chk("R7 input reg", d, 32'hA5);
    endtask

    task automatic t_ignored;
        logic [31:0] d;
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'hB0, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R8 mode kept", d, {24'h0, m_mode});
        rd(8'h10, d); chk("R8 drive kept", d, {24'h0, m_drive});
        rd(8'h20, d); chk("R8 level kept", d, {24'h0, m_level});
        rd(8'h40, d); chk("R8 unmapped read", d, 0);
        rd(8'hB0, d); chk("R8 alias input read", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direct();
        t_timing();
        t_masked();
        t_alias_read();
        t_gating();
        t_sync();
        t_ignored();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule